// File: doc/BRIEF.md
# Interlaced Video Field Detector

This block tells even fields from odd fields in an interlaced video stream. It takes the raw horizontal and vertical sync inputs and makes each of them active-high through a programmable polarity bit. It then counts clock cycles from the most recent horizontal active edge to each vertical active edge. The count is compared against the one taken in the previous field. A longer delay marks an even field and a shorter delay marks an odd field.

The decision is committed only on the trailing edge of vertical sync. At the same moment the block latches a dot-line select output, which tells a half-line vertical scaler whether line 0 or line 1 of a doubled dot row is shown in this field. An 8-bit control register holds the two polarity bits and the dot-line select bit, and exposes the field flag as a read-only bit.

Top module: `field_detector`

## Requirements
- R1: Register bit 0 sets the horizontal sync polarity and bit 1 sets the vertical sync polarity. A bit value of 0 means the input is active-high, and 1 means it is active-low. All edge logic works on the active level after this polarity step.
- R2: A delay counter clears on every horizontal active edge and counts clock cycles until the next one. The value seen on a vertical active edge is the measured delay. If both active edges occur in the same cycle, the measured delay is the counter value before the clear.
- R3: The delay counter saturates at its maximum value (2^CNT_W-1) and does not wrap when horizontal edges stop.
- R4: At a vertical trailing edge, the current delay is compared with the previous field's delay. Longer gives even, and the flag becomes 0. Shorter gives odd, and the flag becomes 1. An equal delay keeps the flag unchanged.
- R5: The field flag changes only at a vertical trailing edge and never at the vertical active edge.
- R6: After reset the flag is 1. The first vertical trailing edge after reset only records the delay and leaves the flag unchanged.
- R7: dot_line_o is latched at each vertical trailing edge as the new flag XOR the dot-line select bit, which is register bit 6. It holds its value between trailing edges, and its reset value is 1.
- R8: A register read returns the field flag in bit 7, the dot-line select bit in bit 6, and the polarity bits in bits 1:0. Bits 5:2 read 0. Bit 7 reports only the field parity, whatever the value of bit 6.
- R9: A register write updates only bits 6, 1 and 0. Written values in bit 7 and in bits 5:2, bit 3 included, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel/system clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| hsync_i | input | 1 | Raw horizontal sync |
| vsync_i | input | 1 | Raw vertical sync |
| reg_we_i | input | 1 | Control register write strobe |
| reg_wdata_i | input | 8 | Control register write data |
| reg_rdata_o | output | 8 | Control register read data |
| field_odd_o | output | 1 | Field flag: 0 even, 1 odd |
| dot_line_o | output | 1 | Dot-line select for half-line scaling |

## Verification
The horizontal counter clear and the vertical delay capture can fall in the same clock cycle. The bench provokes this by moving both sync inputs on the same edge, one full 24-cycle line after the previous horizontal edge. The capture must then take the pre-clear value of 23. The scoreboard judges this through the field flag: the correct result is "even, flag unchanged", while a design that captures the cleared value would wrongly report an odd field.

// File: rtl/fd_pkg.sv
package fd_pkg;
  localparam int HPOL_BIT = 0;
  localparam int VPOL_BIT = 1;
  localparam int DSEL_BIT = 6;
  localparam int FLAG_BIT = 7;
  localparam int REG_W    = 8;

  typedef enum logic {
    FIELD_EVEN = 1'b0,
    FIELD_ODD  = 1'b1
  } field_e;
endpackage

// File: rtl/fd_sync_edge.sv
module fd_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  input  logic neg_pol_i,
  output logic lead_o,
  output logic trail_o
);
  logic [STAGES-1:0] chain_q;
  logic act, act_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= sig_i;
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-2:0], sig_i};
    end
  endgenerate

  assign act = chain_q[STAGES-1] ^ neg_pol_i;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) act_q <= 1'b0;
    else         act_q <= act;

  assign lead_o  = act & ~act_q;
  assign trail_o = ~act & act_q;
endmodule

// File: rtl/fd_delay_cnt.sv
module fd_delay_cnt #(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                 count_o <= '0;
    else if (clear_i)            count_o <= '0;
    else if (count_o != CNT_MAX) count_o <= count_o + 1'b1;
endmodule

// File: rtl/fd_field_decide.sv
module fd_field_decide
  import fd_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cap_i,
  input  logic             dec_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             dsel_i,
  output logic             field_o,
  output logic             dot_o
);
  logic [CNT_W-1:0] meas_q, prev_q;
  logic             have_prev_q;
  field_e           field_q, field_nx;

  always_comb begin
    field_nx = field_q;
    if (have_prev_q) begin
      if (meas_q > prev_q)      field_nx = FIELD_EVEN;
      else if (meas_q < prev_q) field_nx = FIELD_ODD;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      meas_q      <= '0;
      prev_q      <= '0;
      have_prev_q <= 1'b0;
      field_q     <= FIELD_ODD;
      dot_o       <= 1'b1;
    end else begin
      if (cap_i) meas_q <= count_i;
      if (dec_i) begin
        prev_q      <= meas_q;
        have_prev_q <= 1'b1;
        field_q     <= field_nx;
        dot_o       <= field_nx ^ dsel_i;
      end
    end

  assign field_o = field_q;
endmodule

// File: rtl/field_detector.sv
module field_detector
  import fd_pkg::*;
#(
  parameter int CNT_W       = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hsync_i,
  input  logic             vsync_i,
  input  logic             reg_we_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  output logic             field_odd_o,
  output logic             dot_line_o
);
  logic hpol_q, vpol_q, dsel_q;
  logic h_lead, h_trail, v_lead, v_trail;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      hpol_q <= 1'b0;
      vpol_q <= 1'b0;
      dsel_q <= 1'b0;
    end else if (reg_we_i) begin
      hpol_q <= reg_wdata_i[HPOL_BIT];
      vpol_q <= reg_wdata_i[VPOL_BIT];
      dsel_q <= reg_wdata_i[DSEL_BIT];
    end

  always_comb begin
    reg_rdata_o           = '0;
    reg_rdata_o[HPOL_BIT] = hpol_q;
    reg_rdata_o[VPOL_BIT] = vpol_q;
    reg_rdata_o[DSEL_BIT] = dsel_q;
    reg_rdata_o[FLAG_BIT] = field_odd_o;
  end

  fd_sync_edge #(.STAGES(SYNC_STAGES)) u_hsync (
    .clk_i, .rst_ni, .sig_i(hsync_i), .neg_pol_i(hpol_q),
    .lead_o(h_lead), .trail_o(h_trail)
  );

  fd_sync_edge #(.STAGES(SYNC_STAGES)) u_vsync (
    .clk_i, .rst_ni, .sig_i(vsync_i), .neg_pol_i(vpol_q),
    .lead_o(v_lead), .trail_o(v_trail)
  );

  fd_delay_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .clear_i(h_lead), .count_o(cnt)
  );

  fd_field_decide #(.CNT_W(CNT_W)) u_decide (
    .clk_i, .rst_ni, .cap_i(v_lead), .dec_i(v_trail), .count_i(cnt),
    .dsel_i(dsel_q), .field_o(field_odd_o), .dot_o(dot_line_o)
  );

  logic unused_h_trail;
  assign unused_h_trail = h_trail;
endmodule

// File: rtl/fd_checker.sv
module fd_checker #(
  parameter int CNT_W = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             h_lead,
  input logic             v_trail,
  input logic [CNT_W-1:0] cnt,
  input logic             dsel_q,
  input logic             field_odd_o,
  input logic             dot_line_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  assert_cnt_clear_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    h_lead |=> cnt == '0);

  assert_cnt_no_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!h_lead && cnt == CNT_MAX) |=> cnt == CNT_MAX);

  assert_cnt_monotonic_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !h_lead |=> cnt >= $past(cnt));

  assert_flag_only_at_trail_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !v_trail |=> $stable(field_odd_o));

  assert_dot_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !v_trail |=> $stable(dot_line_o));

  assert_dot_value_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v_trail |=> dot_line_o == (field_odd_o ^ $past(dsel_q)));
endmodule

bind field_detector fd_checker #(.CNT_W(CNT_W)) u_fd_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .h_lead(h_lead), .v_trail(v_trail),
  .cnt(cnt), .dsel_q(dsel_q), .field_odd_o(field_odd_o), .dot_line_o(dot_line_o)
);

// File: tb/field_detector_tb_top.sv
module field_detector_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic hs = 1'b0, vs = 1'b0, we = 1'b0;
  logic [7:0] wd = 8'h00;
  wire  [7:0] rd;
  wire        odd, dot;
  logic npol = 1'b0;
  logic mark = 1'b0;
  logic last_f = 1'b1;
  int   checks = 0, fails = 0;
  bit   done = 1'b0;

  typedef struct { logic f; logic d; string tag; } exp_t;
  exp_t q[$];

  field_detector #(.CNT_W(6)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .hsync_i(hs), .vsync_i(vs),
    .reg_we_i(we), .reg_wdata_i(wd), .reg_rdata_o(rd),
    .field_odd_o(odd), .dot_line_o(dot)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] v);
    @(negedge clk); we = 1'b1; wd = v;
    @(negedge clk); we = 1'b0;
  endtask

  // line of 24 cycles; h2v = 0 puts both active edges on the same cycle
  task automatic field(int h2v, logic ef, logic ed, string tag);
    exp_t e;
    @(negedge clk) hs = ~npol;
    repeat (2) @(negedge clk);
    hs = npol;
    repeat (22) @(negedge clk);
    hs = ~npol;
    if (h2v == 0) vs = ~npol;
    else begin
      repeat (h2v) @(negedge clk);
      vs = ~npol;
    end
    repeat (2) @(negedge clk);
    hs = npol;
    repeat (4) @(negedge clk);
    chk({"R5 flag held before trailing edge ", tag}, {7'd0, odd}, {7'd0, last_f});
    vs = npol;
    e.f = ef; e.d = ed; e.tag = tag;
    q.push_back(e);
    last_f = ef;
    mark = 1'b1;
    @(negedge clk) mark = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  // monitor: scoreboard pop after each trailing edge
  initial begin
    forever begin
      @(posedge mark);
      repeat (4) @(negedge clk);
      if (q.size() == 0) begin
        chk("R4 scoreboard empty", 8'd1, 8'd0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk({e.tag, " field flag"}, {7'd0, odd}, {7'd0, e.f});
        chk({e.tag, " dot line"}, {7'd0, dot}, {7'd0, e.d});
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R6 reset flag", {7'd0, odd}, 8'd1);
    chk("R7 reset dot line", {7'd0, dot}, 8'd1);
    chk("R8 reset readback", rd, 8'h80);

    field(10, 1'b1, 1'b1, "R6 first field records only");
    field(20, 1'b0, 1'b0, "R4 longer gives even");
    field(5,  1'b1, 1'b1, "R4 shorter gives odd");
    field(5,  1'b1, 1'b1, "R4 equal keeps odd");
    field(30, 1'b0, 1'b0, "R4 longer gives even again");
    field(30, 1'b0, 1'b0, "R4 equal keeps even");

    wr(8'h40);
    @(negedge clk);
    chk("R8 flag ignores dot select", rd, 8'h40);
    chk("R7 dot line waits for trailing edge", {7'd0, dot}, 8'd0);

    field(10, 1'b1, 1'b0, "R7 odd with select set");
    field(12, 1'b0, 1'b1, "R7 even with select set");
    field(0,  1'b0, 1'b1, "R2 coincident edges use pre-clear count");
    field(80, 1'b0, 1'b1, "R3 saturated longer");
    field(100, 1'b0, 1'b1, "R3 saturated equal keeps");

    // negative polarity phase
    @(negedge clk) rst_n = 1'b0; hs = 1'b0; vs = 1'b0; npol = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1; last_f = 1'b1;
    repeat (100) @(negedge clk);
    hs = 1'b1; vs = 1'b1;
    repeat (10) @(negedge clk);
    wr(8'h03);
    npol = 1'b1;
    repeat (10) @(negedge clk);
    chk("R1 polarity bits readback", rd, 8'h83);
    chk("R6 flag kept after first trailing edge", {7'd0, odd}, 8'd1);

    field(10, 1'b1, 1'b1, "R1 active-low shorter gives odd");
    field(20, 1'b0, 1'b0, "R1 active-low longer gives even");

    wr(8'hFF);
    @(negedge clk);
    chk("R9 bits 7 and 5:2 ignored on write", rd, 8'h43);
    chk("R9 write leaves flag", {7'd0, odd}, 8'd0);
    chk("R7 dot line unchanged by write", {7'd0, dot}, 8'd0);

    repeat (5) @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule